// File: doc/BRIEF.md
# Halting single-step sequencer

This block runs external single-step for a core. When stepping is armed and the core is running, it watches each retired instruction and the exit from reset. It then sets a step-pending bit once the stepped instruction has completed. When the pending bit is set and halting is allowed, it raises a halt request. The request carries a 6-bit reason code that says how the step ended.

The request stays up until the core reports that it has halted. The pending bit stays set while the core sits in debug state. It is cleared on the cycle the core leaves debug state, which is seen as the halted input falling from 1 to 0.

An exception taken to the most privileged level normally blocks completion of the step. It does not block it when the exception is of the system-call kind, or when secure invasive debug is enabled.

Top module: `hstep_seq`

## Requirements
- R1: While `rst_n` is 0, and in the first cycle after it rises, `step_pend` and `halt_req` are 0 and `halt_reason` is 6'b000000.
- R2: Stepping counts as active only while `step_en` is 1 and `halted` is 0. While it is not active, no retire and no reset exit sets `step_pend`.
- R3: A `reset_exit` pulse with stepping active sets `step_pend` at the next clock edge, whatever `halt_allowed` is. A `reset_exit` pulse while `halted` is 1 is illegal.
- R4: A `retire_vld` pulse with stepping active and `halt_allowed` at 1 sets `step_pend` at the next edge. With `halt_allowed` at 0 it leaves `step_pend` unchanged.
- R5: A retire with `retire_exc` at 1 and `retire_tgt` at 2'b11 (the highest level) sets `step_pend` only if `retire_syscall` or `sec_inv_en` is 1. Exceptions to any other target follow R4.
- R6: `halt_req` rises one edge after the edge that sets `step_pend`, provided `halt_allowed` is 1 and `halted` is 0. Once up, it stays up, and so does its reason, until an edge at which `halted` is 1; at that edge it drops.
- R7: The reason is chosen when the request rises. It is 6'b111011 if `prev_not_stepped` is 1, otherwise 6'b011111 if `prev_excl` is 1, otherwise 6'b011011. `halt_reason` is 0 whenever `halt_req` is 0.
- R8: At the edge where `halted` is 0 after being 1 at the previous edge, `step_pend` is cleared. No request is raised at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_vld | input | 1 | One instruction retired this cycle |
| retire_exc | input | 1 | The retired instruction generated or was cut short by an exception |
| retire_tgt | input | 2 | Exception level targeted by that exception |
| retire_syscall | input | 1 | The exception returns to the instruction after the one that raised it |
| reset_exit | input | 1 | Core is leaving reset at the highest level |
| prev_not_stepped | input | 1 | The last instruction ran without being stepped |
| prev_excl | input | 1 | The last instruction was a stepped load-exclusive |
| step_en | input | 1 | External single-step enable |
| halted | input | 1 | Core is in debug state |
| halt_allowed | input | 1 | Halting is currently permitted |
| sec_inv_en | input | 1 | Secure invasive debug is enabled |
| step_pend | output | 1 | Step-pending bit |
| halt_req | output | 1 | Halt request to the halt controller |
| halt_reason | output | 6 | Reason code for the request |

## Verification
Plain retires are compared against retires that raise exceptions to the top level and to a lower level. The exception case is crossed with the system-call flag and the secure-debug enable, which shows that only the top-level target is blocked. Reset exits with halting forbidden are set against retires with halting forbidden, which tells the unconditional set apart from the guarded one. The two prior-instruction flags are driven alone and together, which confirms the order in which the reason code is picked. Long stretches with random inputs and random halt and restart timing are checked against a behavioural model on every cycle. These stretches exercise the hold of the request and the clear on restart.

// File: rtl/hstep_pkg.sv
package hstep_pkg;

    localparam int unsigned RSN_W = 6;

    localparam logic [RSN_W-1:0] RSN_NORMAL = 6'b011011;
    localparam logic [RSN_W-1:0] RSN_EXCL   = 6'b011111;
    localparam logic [RSN_W-1:0] RSN_NOSTEP = 6'b111011;

    typedef struct packed {
        logic pend;
        logic halted;
    } arm_st_t;

    typedef struct packed {
        logic             req;
        logic [RSN_W-1:0] rsn;
    } req_st_t;

endpackage

// File: rtl/hstep_arm.sv
module hstep_arm
    import hstep_pkg::*;
#(
    parameter int unsigned     EL_W   = 2,
    parameter logic [EL_W-1:0] TOP_EL = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_vld,
    input  logic            retire_exc,
    input  logic [EL_W-1:0] retire_tgt,
    input  logic            retire_syscall,
    input  logic            reset_exit,
    input  logic            step_en,
    input  logic            halted,
    input  logic            halt_allowed,
    input  logic            sec_inv_en,
    output logic            pend,
    output logic            restart_ev
);

    arm_st_t st_d, st_q;
    logic    active;
    logic    advance;

    assign restart_ev = st_q.halted & ~halted;

    always_comb begin
        st_d        = st_q;
        st_d.halted = halted;
        active      = step_en & ~halted;
        advance     = ~(retire_exc && (retire_tgt == TOP_EL)) | retire_syscall | sec_inv_en;
        if (restart_ev) begin
            st_d.pend = 1'b0;
        end else if (active && reset_exit) begin
            st_d.pend = 1'b1;
        end else if (active && halt_allowed && retire_vld && advance) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    AST_RESET_EXIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        reset_exit |-> !halted); // R3

    AST_INACTIVE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en || halted) |=> !$rose(pend)); // R2

    AST_TOP_EXC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && retire_exc && retire_tgt == TOP_EL && !retire_syscall
         && !sec_inv_en && !reset_exit && !pend) |=> !pend); // R5

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |=> !pend); // R8

endmodule

// File: rtl/hstep_req.sv
module hstep_req
    import hstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             restart_ev,
    input  logic             halted,
    input  logic             halt_allowed,
    input  logic             not_stepped,
    input  logic             stepped_excl,
    output logic             req,
    output logic [RSN_W-1:0] reason
);

    req_st_t          st_d, st_q;
    logic [RSN_W-1:0] pick;

    always_comb begin
        if (not_stepped) begin
            pick = RSN_NOSTEP;
        end else if (stepped_excl) begin
            pick = RSN_EXCL;
        end else begin
            pick = RSN_NORMAL;
        end
    end

    always_comb begin
        st_d = st_q;
        if (halted) begin
            st_d = '0;
        end else if (!st_q.req && pend && halt_allowed && !restart_ev) begin
            st_d.req = 1'b1;
            st_d.rsn = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign reason = st_q.rsn;

    AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && halt_allowed && !halted && !restart_ev && !req) |=> req); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !halted) |=> (req && $stable(reason))); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !req); // R6

    AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> pend); // R6

    AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (reason == RSN_NORMAL || reason == RSN_EXCL || reason == RSN_NOSTEP)); // R7

    AST_REASON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (reason == '0)); // R7

endmodule

// File: rtl/hstep_seq.sv
module hstep_seq
    import hstep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retire_vld,
    input  logic       retire_exc,
    input  logic [1:0] retire_tgt,
    input  logic       retire_syscall,
    input  logic       reset_exit,
    input  logic       prev_not_stepped,
    input  logic       prev_excl,
    input  logic       step_en,
    input  logic       halted,
    input  logic       halt_allowed,
    input  logic       sec_inv_en,
    output logic       step_pend,
    output logic       halt_req,
    output logic [5:0] halt_reason
);

    logic pend_w;
    logic restart_w;

    hstep_arm #(
        .EL_W   (2),
        .TOP_EL (2'b11)
    ) u_arm (
        .clk            (clk),
        .rst_n          (rst_n),
        .retire_vld     (retire_vld),
        .retire_exc     (retire_exc),
        .retire_tgt     (retire_tgt),
        .retire_syscall (retire_syscall),
        .reset_exit     (reset_exit),
        .step_en        (step_en),
        .halted         (halted),
        .halt_allowed   (halt_allowed),
        .sec_inv_en     (sec_inv_en),
        .pend           (pend_w),
        .restart_ev     (restart_w)
    );

    hstep_req u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend         (pend_w),
        .restart_ev   (restart_w),
        .halted       (halted),
        .halt_allowed (halt_allowed),
        .not_stepped  (prev_not_stepped),
        .stepped_excl (prev_excl),
        .req          (halt_req),
        .reason       (halt_reason)
    );

    assign step_pend = pend_w;

endmodule

// File: tb/hstep_seq_tb.sv
module hstep_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       retire_vld = 0, retire_exc = 0, retire_syscall = 0, reset_exit = 0;
    logic [1:0] retire_tgt = 0;
    logic       prev_not_stepped = 0, prev_excl = 0, step_en = 0, halted = 0;
    logic       halt_allowed = 0, sec_inv_en = 0;
    logic       step_pend, halt_req;
    logic [5:0] halt_reason;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit       m_pend, m_req, m_prev_halted;
    bit [5:0] m_rsn;

    always #2 clk = ~clk;

    hstep_seq u_dut (
        .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_exc(retire_exc),
        .retire_tgt(retire_tgt), .retire_syscall(retire_syscall), .reset_exit(reset_exit),
        .prev_not_stepped(prev_not_stepped), .prev_excl(prev_excl), .step_en(step_en),
        .halted(halted), .halt_allowed(halt_allowed), .sec_inv_en(sec_inv_en),
        .step_pend(step_pend), .halt_req(halt_req), .halt_reason(halt_reason)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_req = 0; m_rsn = 0; m_prev_halted = 0;
        end else begin
            bit leaving, running, blocked, new_pend, new_req;
            bit [5:0] new_rsn;
            leaving = m_prev_halted && !halted;
            running = step_en && !halted;
            blocked = retire_exc && retire_tgt == 2'd3 && !retire_syscall && !sec_inv_en;
            new_pend = m_pend;
            if (leaving) new_pend = 0;
            else if (running && reset_exit) new_pend = 1;
            else if (running && halt_allowed && retire_vld && !blocked) new_pend = 1;
            new_req = m_req; new_rsn = m_rsn;
            if (halted) begin
                new_req = 0; new_rsn = 0;
            end else if (!m_req && m_pend && halt_allowed && !leaving) begin
                new_req = 1;
                new_rsn = prev_not_stepped ? 6'b111011 : (prev_excl ? 6'b011111 : 6'b011011);
            end
            m_pend = new_pend; m_req = new_req; m_rsn = new_rsn;
            m_prev_halted = halted;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock, then compare every output with the model (R4 pend, R6 req, R7 reason)
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk("R4 model pend", step_pend, m_pend);
        chk("R6 model req", halt_req, m_req);
        chk("R7 model reason", halt_reason, m_rsn);
    endtask

    task automatic clear_in();
        retire_vld = 0; retire_exc = 0; retire_tgt = 0; retire_syscall = 0;
        reset_exit = 0; prev_not_stepped = 0; prev_excl = 0; sec_inv_en = 0;
    endtask

    task automatic halt_and_restart(input string tag);
        halted = 1; tick();
        chk({tag, " req drops on halt"}, halt_req, 0);
        halted = 0; tick();
        chk("R8 pend cleared on restart", step_pend, 0);
        chk("R8 no request at restart", halt_req, 0);
    endtask

    task automatic one_step(input bit exc, input bit [1:0] tgt, input bit sys, input bit sec,
                            input bit ns, input bit ex, input bit exp_pend,
                            input int exp_rsn, input string tag);
        step_en = 1; halt_allowed = 1;
        retire_vld = 1; retire_exc = exc; retire_tgt = tgt; retire_syscall = sys;
        sec_inv_en = sec; prev_not_stepped = ns; prev_excl = ex;
        tick();
        retire_vld = 0;
        chk({tag, " pend"}, step_pend, exp_pend);
        tick();
        chk({tag, " req"}, halt_req, exp_pend);
        if (exp_pend) begin
            chk({tag, " reason"}, halt_reason, exp_rsn);
            halt_and_restart("R6");
        end
        clear_in();
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks + 1 - 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset pend", step_pend, 0);
        chk("R1 reset req", halt_req, 0);
        rst_n = 1;
        tick();
        chk("R1 reason after reset", halt_reason, 0);

        one_step(0, 2'd0, 0, 0, 0, 0, 1, 6'b011011, "R4 plain R7");
        one_step(0, 2'd0, 0, 0, 1, 1, 1, 6'b111011, "R7 nostep priority");
        one_step(0, 2'd0, 0, 0, 0, 1, 1, 6'b011111, "R7 exclusive");
        one_step(1, 2'd3, 0, 0, 0, 0, 0, 0, "R5 top blocked");
        one_step(1, 2'd3, 1, 0, 0, 0, 1, 6'b011011, "R5 top syscall");
        one_step(1, 2'd3, 0, 1, 0, 0, 1, 6'b011011, "R5 top secure");
        one_step(1, 2'd1, 0, 0, 0, 0, 1, 6'b011011, "R5 lower target");

        // R2: step disabled
        step_en = 0; halt_allowed = 1; retire_vld = 1; tick();
        retire_vld = 0;
        chk("R2 disabled no pend", step_pend, 0);
        // R2: retire and reset exit-free while halted
        step_en = 1; halted = 1; retire_vld = 1; tick();
        retire_vld = 0;
        chk("R2 halted no pend", step_pend, 0);
        halted = 0; tick();
        chk("R2 still clear", step_pend, 0);

        // R4: halting forbidden blocks retire
        halt_allowed = 0; retire_vld = 1; tick();
        retire_vld = 0;
        chk("R4 not allowed no pend", step_pend, 0);
        // R3: reset exit sets regardless of halt_allowed
        reset_exit = 1; tick();
        reset_exit = 0;
        chk("R3 reset exit pend", step_pend, 1);
        tick();
        chk("R6 no req while forbidden", halt_req, 0);
        halt_allowed = 1; tick();
        chk("R6 req after allow", halt_req, 1);
        // R6: hold with halt_allowed dropped and flags changing
        halt_allowed = 0; prev_not_stepped = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R6 req held", halt_req, 1);
            chk("R6 reason held", halt_reason, 6'b011011);
        end
        clear_in();
        halt_and_restart("R6");

        // random phase, model compared each cycle
        for (int i = 0; i < 2000; i++) begin
            retire_vld = $urandom_range(0, 1); retire_exc = $urandom_range(0, 1);
            retire_tgt = 2'($urandom_range(0, 3)); retire_syscall = $urandom_range(0, 1);
            sec_inv_en = $urandom_range(0, 3) == 0; prev_not_stepped = $urandom_range(0, 3) == 0;
            prev_excl = $urandom_range(0, 2) == 0; step_en = $urandom_range(0, 5) != 0;
            halt_allowed = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 5) == 0) halted = ~halted;
            reset_exit = !halted && ($urandom_range(0, 15) == 0);
            tick();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule